// File: doc/BRIEF.md
# Descriptor Queue with Head/Tail Push and Size Accounting

This block is a single hardware queue of 32-bit descriptor pointers that software drives through a four-word register window. A side (control) register stages a push direction and a per-packet size. A write to the pointer register commits a push of the written pointer, either at the tail or at the head, using the staged values. A read of the pointer register pops the head entry. The block keeps an entry count and a running total of the sizes of all queued entries, and exposes both through read-only registers.

Software that wants the size of the next packet reads the side register first. That read pops the head entry into a holding slot and returns its size. The pointer read that follows returns the held pointer without popping again. A separate 64-bit port writes the side value and the pointer in one transaction, so no other agent can slip in between the two halves of a push. A push into a full queue is discarded and sets a sticky overflow flag.

Top module: `dq_queue`

## Requirements
- R1: A write to the pointer register (address 3) with direction bit 0 staged appends the written pointer at the tail, so entries pushed this way pop in first-in first-out order.
- R2: A write to the pointer register with direction bit 1 staged (side register bit 31) places the pointer at the head, so it is the next entry popped.
- R3: A read of the pointer register with no held entry returns the head pointer and removes it. The entry count drops by one. On an empty queue the read returns zero and changes no state.
- R4: In the side register (address 2), bits 16:0 carry the packet size and bit 31 the direction. Bits 30:17 are reserved: the values written there are ignored, and side reads return zero there and in bit 31.
- R5: The staged side value returns to zero (tail direction, size zero) after every pointer-register write. A pointer write with no side write before it therefore pushes at the tail with size zero.
- R6: The total register (address 1) equals the sum of the sizes of the entries currently queued. It is updated in the same clock as the push or pop that changes it.
- R7: A read of the side register on a non-empty queue pops the head entry into a holding slot and returns its size. The next pointer read returns the held pointer and does not pop again. A side read on an empty queue returns zero and changes no state.
- R8: An atomic write pushes one entry. Bits 63:32 carry the side value (bit 63 direction, bits 48:32 size) and bits 31:0 carry the pointer. An atomic write in the same cycle as a plain register access is ignored. An atomic write leaves the staged side value unchanged.
- R9: A push into a full queue (16 entries) is dropped. It sets an overflow flag that stays set until reset and is visible on a port and in bit 31 of the count register (address 0), whose low bits hold the entry count.
- R10: Read data appears on the read data port, with its valid strobe high, in the cycle after the read request. Writes to addresses 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Plain register access request |
| regWrite | input | 1 | 1 for a write, 0 for a read |
| regAddr | input | 2 | Register address: 0 count, 1 total, 2 side, 3 pointer |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after the request |
| regRdValid | output | 1 | High in the cycle regRdata holds a read result |
| atomValid | input | 1 | Atomic push request |
| atomData | input | 64 | Side value in 63:32, pointer in 31:0 |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The bench mixes head and tail pushes and checks the pop order. A design that ignored the direction bit, or moved the wrong index, would return the entries in the wrong order. It pops through the side register and then reads the pointer, so a design that popped twice would show a count too low by one and skip an entry. Pushes issued without a prior side write expose a staged value that is not cleared, because the running total would grow by a stale size. The bench also fills the queue after its indices have wrapped and pushes once more. It then checks that the extra entry is dropped, the flag sticks and the sixteen survivors pop intact. An atomic write that collides with a plain access must leave both the count and the total unchanged.

// File: rtl/dq_pkg.sv
package dq_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_TOTAL = 2'd1,
    SEL_SIDE  = 2'd2,
    SEL_PTR   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    push;          // commit a push this cycle
    logic    pushAtomic;    // push fields come from the atomic port
    logic    stageWr;       // side register write
    logic    popHead;       // remove head entry
    logic    popToHold;     // removed entry goes to holding slot
    logic    readReq;       // a read is being served
    logic    readFromHold;  // pointer read served from holding slot
    regSel_e rdSel;         // which register is read
  } dqStrobe_t;

endpackage

// File: rtl/dq_ctrl.sv
module dq_ctrl
  import dq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regValid,
  input  logic       regWrite,
  input  logic [1:0] regAddr,
  input  logic       atomValid,
  input  logic       notEmpty,
  output dqStrobe_t  strobe
);

  logic    pending;
  regSel_e sel;

  assign sel = regSel_e'(regAddr);

  always_comb begin
    strobe = '0;
    strobe.rdSel = sel;
    if (regValid && regWrite) begin
      if (sel == SEL_SIDE) strobe.stageWr = 1'b1;
      if (sel == SEL_PTR)  strobe.push    = 1'b1;
    end
    if (regValid && !regWrite) begin
      strobe.readReq = 1'b1;
      if (sel == SEL_SIDE) begin
        strobe.popHead   = notEmpty;
        strobe.popToHold = notEmpty;
      end
      if (sel == SEL_PTR) begin
        if (pending) strobe.readFromHold = 1'b1;
        else         strobe.popHead      = notEmpty;
      end
    end
    // plain access has priority; a colliding atomic push is discarded
    if (atomValid && !regValid) begin
      strobe.push       = 1'b1;
      strobe.pushAtomic = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobe.readReq && sel == SEL_SIDE) begin
      pending <= notEmpty;
    end else if (strobe.readReq && sel == SEL_PTR) begin
      pending <= 1'b0;
    end
  end

  // R3
  no_push_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.push && strobe.popHead));

  // R7
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.readReq && sel == SEL_PTR) |=> !pending);

endmodule

// File: rtl/dq_datapath.sv
module dq_datapath
  import dq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PTR_W  = 32,
  parameter int SIZE_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  dqStrobe_t        strobe,
  input  logic [31:0]      regWdata,
  input  logic [63:0]      atomData,
  output logic [31:0]      rdData,
  output logic             rdValid,
  output logic             notEmpty,
  output logic             ovf
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int TOT_W = SIZE_W + CNT_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0]  ptrMem  [DEPTH];
  logic [SIZE_W-1:0] sizeMem [DEPTH];

  logic [IDX_W-1:0]  headIdx, tailIdx, headDec, headInc, tailInc, wrIdx;
  logic [CNT_W-1:0]  count;
  logic [TOT_W-1:0]  total;
  logic              stageDir;
  logic [SIZE_W-1:0] stageSize;
  logic [PTR_W-1:0]  holdPtr;

  logic              pushDir, full, doPush;
  logic [SIZE_W-1:0] pushSize;
  logic [PTR_W-1:0]  pushPtr;
  logic [31:0]       rdNext;

  assign full     = (count == FULL_CNT);
  assign notEmpty = (count != '0);
  assign doPush   = strobe.push && !full;

  assign pushDir  = strobe.pushAtomic ? atomData[63]           : stageDir;
  assign pushSize = strobe.pushAtomic ? atomData[32 +: SIZE_W] : stageSize;
  assign pushPtr  = strobe.pushAtomic ? atomData[PTR_W-1:0]    : regWdata[PTR_W-1:0];

  assign headDec = (headIdx == '0)      ? LAST_IDX : headIdx - 1'b1;
  assign headInc = (headIdx == LAST_IDX) ? '0      : headIdx + 1'b1;
  assign tailInc = (tailIdx == LAST_IDX) ? '0      : tailIdx + 1'b1;
  assign wrIdx   = pushDir ? headDec : tailIdx;

  // entry storage
  always_ff @(posedge clk) begin
    if (doPush) begin
      ptrMem[wrIdx]  <= pushPtr;
      sizeMem[wrIdx] <= pushSize;
    end
  end

  // indices, count and running total
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
      total   <= '0;
      ovf     <= 1'b0;
    end else begin
      if (doPush) begin
        if (pushDir) headIdx <= headDec;
        else         tailIdx <= tailInc;
        count <= count + 1'b1;
        total <= total + TOT_W'(pushSize);
      end else if (strobe.push) begin
        ovf <= 1'b1;
      end
      if (strobe.popHead) begin
        headIdx <= headInc;
        count   <= count - 1'b1;
        total   <= total - TOT_W'(sizeMem[headIdx]);
      end
    end
  end

  // staged side value and holding slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageDir  <= 1'b0;
      stageSize <= '0;
      holdPtr   <= '0;
    end else begin
      if (strobe.stageWr) begin
        stageDir  <= regWdata[31];
        stageSize <= regWdata[SIZE_W-1:0];
      end else if (strobe.push && !strobe.pushAtomic) begin
        stageDir  <= 1'b0;
        stageSize <= '0;
      end
      if (strobe.popToHold) holdPtr <= ptrMem[headIdx];
    end
  end

  // read mux
  always_comb begin
    rdNext = '0;
    unique case (strobe.rdSel)
      SEL_COUNT: rdNext = {ovf, 31'(count)};
      SEL_TOTAL: rdNext = 32'(total);
      SEL_SIDE:  rdNext = notEmpty ? 32'(sizeMem[headIdx]) : '0;
      SEL_PTR: begin
        if (strobe.readFromHold) rdNext = 32'(holdPtr);
        else if (notEmpty)       rdNext = 32'(ptrMem[headIdx]);
        else                     rdNext = '0;
      end
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.readReq;
      if (strobe.readReq) rdData <= rdNext;
    end
  end

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> ovf);

  // R1
  push_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !full) |=> count == $past(count) + 1'b1);

  // R3
  pop_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popHead |=> count == $past(count) - 1'b1);

  // R6
  empty_total_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> (total == '0));

  // R10
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.readReq |=> rdValid);

endmodule

// File: rtl/dq_queue.sv
module dq_queue
  import dq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PTR_W  = 32,
  parameter int SIZE_W = 17
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regValid,
  input  logic        regWrite,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        regRdValid,
  input  logic        atomValid,
  input  logic [63:0] atomData,
  output logic        ovfFlag
);

  dqStrobe_t strobe;
  logic      notEmpty;

  dq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .atomValid(atomValid),
    .notEmpty (notEmpty),
    .strobe   (strobe)
  );

  dq_datapath #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .SIZE_W(SIZE_W)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regWdata(regWdata),
    .atomData(atomData),
    .rdData  (regRdata),
    .rdValid (regRdValid),
    .notEmpty(notEmpty),
    .ovf     (ovfFlag)
  );

endmodule

// File: tb/dq_queue_test.sv
`timescale 1ns/1ps
module dq_queue_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regRdValid;
  logic        atomValid = 1'b0;
  logic [63:0] atomData = '0;
  logic        ovfFlag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dq_queue uut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regRdValid(regRdValid), .atomValid(atomValid), .atomData(atomData),
    .ovfFlag(ovfFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
    check("R10 read valid", {31'd0, regRdValid}, 32'd1);
    d = regRdata;
  endtask

  task automatic push(input logic [31:0] p, input logic [16:0] sz, input logic head);
    wr(2'd2, {head, 14'd0, sz});
    wr(2'd3, p);
  endtask

  task automatic expectState(input string req, input int cnt, input int tot);
    logic [31:0] d;
    rd(2'd0, d);
    check({req, " count"}, {1'b0, d[30:0]}, cnt);
    rd(2'd1, d);
    check({req, " total"}, d, tot);
  endtask

  task automatic expectPop(input string req, input logic [31:0] p);
    logic [31:0] d;
    rd(2'd3, d);
    check(req, d, p);
  endtask

  task automatic testReset();
    logic [31:0] d;
    expectState("R6 reset", 0, 0);
    check("R9 reset flag", {31'd0, ovfFlag}, 32'd0);
    rd(2'd3, d);
    check("R3 empty pointer read", d, 32'd0);
    rd(2'd2, d);
    check("R7 empty side read", d, 32'd0);
    expectState("R3 empty read no change", 0, 0);
  endtask

  task automatic testTailOrder();
    push(32'hA000_0001, 17'd10, 1'b0);
    push(32'hA000_0002, 17'd20, 1'b0);
    push(32'hA000_0003, 17'd30, 1'b0);
    expectState("R6 after tail pushes", 3, 60);
    expectPop("R1 first out", 32'hA000_0001);
    expectState("R6 after one pop", 2, 50);
    expectPop("R1 second out", 32'hA000_0002);
    expectPop("R1 third out", 32'hA000_0003);
    expectState("R3 drained", 0, 0);
  endtask

  task automatic testHeadPush();
    push(32'hB000_0001, 17'd1, 1'b0);
    push(32'hB000_0002, 17'd2, 1'b0);
    push(32'hB000_0003, 17'd4, 1'b1);
    expectState("R6 mixed pushes", 3, 7);
    expectPop("R2 head entry first", 32'hB000_0003);
    expectPop("R2 then old head", 32'hB000_0001);
    expectPop("R2 then tail", 32'hB000_0002);
  endtask

  task automatic testSideRead();
    logic [31:0] d;
    push(32'hC000_0001, 17'h1_2345, 1'b0);
    push(32'hC000_0002, 17'd9, 1'b0);
    rd(2'd2, d);
    check("R7 side read size", d, 32'h0001_2345);
    expectState("R7 side read pops", 1, 9);
    expectPop("R7 held pointer", 32'hC000_0001);
    expectState("R7 no second pop", 1, 9);
    expectPop("R7 next entry", 32'hC000_0002);
  endtask

  task automatic testReserved();
    logic [31:0] d;
    wr(2'd2, 32'h7FFE_0005);
    wr(2'd3, 32'hD000_0001);
    expectState("R4 reserved bits ignored", 1, 5);
    wr(2'd2, 32'h8000_0003);
    wr(2'd3, 32'hD000_0002);
    rd(2'd2, d);
    check("R4 side readback bit31 zero", d, 32'd3);
    expectPop("R4 head direction honoured", 32'hD000_0002);
    expectPop("R4 remaining", 32'hD000_0001);
  endtask

  task automatic testStageClear();
    push(32'hE000_0001, 17'd7, 1'b1);
    wr(2'd3, 32'hE000_0002);
    expectState("R5 second push size zero", 2, 7);
    expectPop("R5 first pushed", 32'hE000_0001);
    expectState("R5 popped size", 1, 0);
    expectPop("R5 tail default", 32'hE000_0002);
  endtask

  task automatic testAtomic();
    wr(2'd2, 32'h0000_0011);
    @(negedge clk);
    atomValid = 1'b1; atomData = {32'h0000_0064, 32'hF000_0001};
    @(negedge clk);
    atomData = {32'h8000_0001, 32'hF000_0002};
    @(negedge clk);
    atomValid = 1'b0;
    expectState("R8 atomic pushes", 2, 101);
    // collision with a plain read: atomic dropped
    @(negedge clk);
    atomValid = 1'b1; atomData = {32'h0000_0005, 32'hF000_0003};
    regValid = 1'b1; regWrite = 1'b0; regAddr = 2'd0;
    @(negedge clk);
    atomValid = 1'b0; regValid = 1'b0;
    expectState("R8 collision ignored", 2, 101);
    // staged value 0x11 survives atomic pushes
    wr(2'd3, 32'hF000_0004);
    expectState("R8 staged kept", 3, 118);
    expectPop("R8 atomic head", 32'hF000_0002);
    expectPop("R8 atomic tail", 32'hF000_0001);
    expectPop("R8 staged push", 32'hF000_0004);
  endtask

  task automatic testWrites01();
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h1234_5678);
    expectState("R10 writes to 0 and 1 ignored", 0, 0);
  endtask

  task automatic testFull();
    logic [31:0] d;
    for (int i = 0; i < 16; i++) push(32'h100 + i, 17'd1, 1'b0);
    expectState("R9 full", 16, 16);
    check("R9 flag before", {31'd0, ovfFlag}, 32'd0);
    push(32'hDEAD, 17'd50, 1'b0);
    expectState("R9 dropped push", 16, 16);
    check("R9 flag set", {31'd0, ovfFlag}, 32'd1);
    rd(2'd0, d);
    check("R9 count bit31", {31'd0, d[31]}, 32'd1);
    for (int i = 0; i < 16; i++) expectPop("R9 survivor order", 32'h100 + i);
    expectState("R9 drained", 0, 0);
    check("R9 flag sticky", {31'd0, ovfFlag}, 32'd1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTailOrder();
    testHeadPush();
    testSideRead();
    testReserved();
    testStageClear();
    testAtomic();
    testWrites01();
    testFull();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule